// File: doc/BRIEF.md
# Per-Core Clock Divider Bank with Staged Reload

This block turns one shared parent clock into a separate clock-enable strobe for each of up to four processor cores. Each core has its own integer divide ratio, and its strobe goes high for one parent cycle out of every N, where N is the ratio in force. Software sets the ratios through a small register port with three mapped words: a control word, a second control word and a divider word.

A ratio written to the divider word has no effect on its own. Software first marks which cores should take their new value by setting per-core reload-enable bits in the control word. It then raises the global trigger bit. Each selected core holds the new ratio back until its current division period has ended, so no strobe is ever cut short or repeated. Software later clears the trigger and the reload bits, and doing so leaves the applied ratios as they are. The control word also holds per-core reset-request bits, which drive an output, and a sticky per-core completion flag. The second control word stores a fabric ratio that software can read back.

Top module: `core_div_bank`

## Requirements
- R1: After reset every applied ratio is 1, every strobe in core_tick is high on every cycle, core_rst_req is all zero, and all three mapped words read 0.
- R2: In the divider word at byte offset 0xC, core n's requested ratio sits in bits [8n+5:8n]. A write stores only those six bits of each byte lane, a read returns exactly the stored bits, and all other bits read 0.
- R3: Writing the divider word alone does not change any strobe pattern.
- R4: In the control word at offset 0x0, bit 20+n is core n's reload-enable and bit 24 is the trigger. A control write that sets bit 24 while the stored trigger is 0 stages the divider field of exactly those cores whose bit 20+n is set in that same write.
- R5: A staged ratio is applied at the end of the core's current period. That period keeps its old length, and the next period has the new length.
- R6: With applied ratio N, core n's strobe is high for exactly one cycle out of every N cycles.
- R7: When staged, a requested ratio of 0 becomes 1, a requested ratio above 3 becomes 3, and values 1 to 3 are used unchanged.
- R8: A control write that clears the trigger or the reload bits, or one that sets bit 24 while the stored trigger is already 1, leaves the applied ratios unchanged.
- R9: The second control word at offset 0x8 stores bits [21:16] as the fabric ratio and reads them back. Its other bits read 0.
- R10: Control bits [15:8] are reset-request bits that are stored and read back, and core_rst_req[n] equals control bit 8+n.
- R11: Control bit n (bits [3:0]) reads 0 from the moment core n is staged by a trigger, reads 1 from the moment its new ratio is applied, and stays 1 until core n is next staged. Writes to these bits have no effect.
- R12: Writes to unmapped offsets are ignored, and reads from unmapped offsets return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Parent clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Write strobe for the register port |
| bus_addr | input | ADDR_W | Byte offset of the accessed word |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for bus_addr, combinational |
| core_tick | output | NUM_CORES | Per-core one-cycle clock-enable strobes |
| core_rst_req | output | NUM_CORES | Per-core reset-request levels |

## Verification
The bench fires the trigger at each possible phase of a running period. A design that applied the ratio at once, rather than at the period end, would emit a short period, and a design that reset its counter on the trigger would emit a long one. It sets different reload masks across the cores and checks that an unselected core keeps its old ratio even when its divider field has changed. It also repeats a trigger write while the trigger bit is already set, which catches a design that stages on the level of the bit and not on its rising edge. It writes out-of-range requested ratios (0 and values above 3) and garbage in the upper bits of each byte lane, to catch a design that clamps in the register itself or stores more than six bits.

// File: rtl/core_div_pkg.sv
package core_div_pkg;

   // byte offsets of the mapped words
   localparam logic [3:0] OFS_CTRL  = 4'h0;
   localparam logic [3:0] OFS_CTRL2 = 4'h8;
   localparam logic [3:0] OFS_DIV   = 4'hC;

   // control word layout: software depends on these positions
   localparam int DONE_LSB   = 0;
   localparam int RSTREQ_LSB = 8;
   localparam int RSTREQ_W   = 8;
   localparam int RELOAD_LSB = 20;
   localparam int TRIG_BIT   = 24;

   // second control word
   localparam int FABRIC_LSB = 16;
   localparam int FABRIC_W   = 6;

   // divider word: one byte lane per core
   localparam int LANE_W = 8;

endpackage

// File: rtl/core_div_regs.sv
module core_div_regs
   import core_div_pkg::*;
#(
   parameter int NUM_CORES = 4,
   parameter int RATIO_W   = 6,
   parameter int ADDR_W    = 4,
   parameter int DATA_W    = 32
) (
   input  logic                               clk,
   input  logic                               rst_n,
   input  logic                               bus_we,
   input  logic [ADDR_W-1:0]                  bus_addr,
   input  logic [DATA_W-1:0]                  bus_wdata,
   output logic [DATA_W-1:0]                  bus_rdata,
   input  logic [NUM_CORES-1:0]               done_i,
   output logic [NUM_CORES-1:0][RATIO_W-1:0]  div_field,
   output logic [NUM_CORES-1:0]               capture,
   output logic [NUM_CORES-1:0]               rst_req
);

   logic                              trig_q;
   logic [NUM_CORES-1:0]              reload_q;
   logic [RSTREQ_W-1:0]               rstreq_q;
   logic [FABRIC_W-1:0]               fabric_q;
   logic [NUM_CORES-1:0][RATIO_W-1:0] div_q;

   logic sel_ctrl, sel_ctrl2, sel_div;
   logic trig_edge;
   logic unused_wdata;

   assign sel_ctrl  = (bus_addr == ADDR_W'(OFS_CTRL));
   assign sel_ctrl2 = (bus_addr == ADDR_W'(OFS_CTRL2));
   assign sel_div   = (bus_addr == ADDR_W'(OFS_DIV));

   // staging happens only on a 0 -> 1 change of the stored trigger bit
   assign trig_edge = bus_we && sel_ctrl && bus_wdata[TRIG_BIT] && !trig_q;

   for (genvar n = 0; n < NUM_CORES; n++) begin : g_cap
      assign capture[n] = trig_edge && bus_wdata[RELOAD_LSB + n];
   end

   assign div_field    = div_q;
   assign rst_req      = rstreq_q[NUM_CORES-1:0];
   assign unused_wdata = ^bus_wdata;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         trig_q   <= 1'b0;
         reload_q <= '0;
         rstreq_q <= '0;
         fabric_q <= '0;
         div_q    <= '0;
      end else if (bus_we) begin
         if (sel_ctrl) begin
            trig_q   <= bus_wdata[TRIG_BIT];
            reload_q <= bus_wdata[RELOAD_LSB +: NUM_CORES];
            rstreq_q <= bus_wdata[RSTREQ_LSB +: RSTREQ_W];
         end
         if (sel_ctrl2) begin
            fabric_q <= bus_wdata[FABRIC_LSB +: FABRIC_W];
         end
         if (sel_div) begin
            for (int n = 0; n < NUM_CORES; n++) begin
               div_q[n] <= bus_wdata[n*LANE_W +: RATIO_W];
            end
         end
      end
   end

   always_comb begin
      bus_rdata = '0;
      if (sel_ctrl) begin
         bus_rdata[TRIG_BIT]                   = trig_q;
         bus_rdata[RELOAD_LSB +: NUM_CORES]    = reload_q;
         bus_rdata[RSTREQ_LSB +: RSTREQ_W]     = rstreq_q;
         bus_rdata[DONE_LSB +: NUM_CORES]      = done_i;
      end else if (sel_ctrl2) begin
         bus_rdata[FABRIC_LSB +: FABRIC_W]     = fabric_q;
      end else if (sel_div) begin
         for (int n = 0; n < NUM_CORES; n++) begin
            bus_rdata[n*LANE_W +: RATIO_W] = div_q[n];
         end
      end
   end

endmodule

// File: rtl/core_div_lane.sv
module core_div_lane #(
   parameter int RATIO_W   = 6,
   parameter int MAX_RATIO = 3
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               capture,
   input  logic [RATIO_W-1:0] req_ratio,
   output logic               tick,
   output logic [RATIO_W-1:0] ratio_o,
   output logic               done_o
);

   localparam logic [RATIO_W-1:0] RATIO_MAX = RATIO_W'(MAX_RATIO);
   localparam logic [RATIO_W-1:0] RATIO_ONE = RATIO_W'(1);

   logic [RATIO_W-1:0] cnt_q;
   logic [RATIO_W-1:0] ratio_q;
   logic [RATIO_W-1:0] stage_q;
   logic               pend_q;
   logic               done_q;
   logic [RATIO_W-1:0] clamped;

   always_comb begin
      if (req_ratio == '0)            clamped = RATIO_ONE;
      else if (req_ratio > RATIO_MAX) clamped = RATIO_MAX;
      else                            clamped = req_ratio;
   end

   // last cycle of the running period
   assign tick    = (cnt_q == ratio_q - RATIO_ONE);
   assign ratio_o = ratio_q;
   assign done_o  = done_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q   <= '0;
         ratio_q <= RATIO_ONE;
         stage_q <= RATIO_ONE;
         pend_q  <= 1'b0;
         done_q  <= 1'b0;
      end else begin
         if (tick) begin
            cnt_q  <= '0;
            pend_q <= 1'b0;
            if (pend_q) begin
               ratio_q <= stage_q;
               done_q  <= 1'b1;
            end
         end else begin
            cnt_q <= cnt_q + RATIO_ONE;
         end
         // a fresh capture wins over a same-cycle apply
         if (capture) begin
            stage_q <= clamped;
            pend_q  <= 1'b1;
            done_q  <= 1'b0;
         end
      end
   end

endmodule

// File: rtl/core_div_bank.sv
module core_div_bank
   import core_div_pkg::*;
#(
   parameter int NUM_CORES = 4,
   parameter int RATIO_W   = 6,
   parameter int MAX_RATIO = 3,
   parameter int ADDR_W    = 4,
   parameter int DATA_W    = 32
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 bus_we,
   input  logic [ADDR_W-1:0]    bus_addr,
   input  logic [DATA_W-1:0]    bus_wdata,
   output logic [DATA_W-1:0]    bus_rdata,
   output logic [NUM_CORES-1:0] core_tick,
   output logic [NUM_CORES-1:0] core_rst_req
);

   if (NUM_CORES < 1 || NUM_CORES > 4) begin : g_bad_cores
      $error("NUM_CORES must lie in 1..4");
   end
   if (RATIO_W < 2 || RATIO_W > LANE_W) begin : g_bad_ratio_w
      $error("RATIO_W must lie in 2..8");
   end
   if (MAX_RATIO < 1 || MAX_RATIO >= (1 << RATIO_W)) begin : g_bad_max
      $error("MAX_RATIO does not fit RATIO_W");
   end
   if (DATA_W < 32 || ADDR_W < 4) begin : g_bad_bus
      $error("register port needs DATA_W >= 32 and ADDR_W >= 4");
   end

   logic [NUM_CORES-1:0][RATIO_W-1:0] div_field;
   logic [NUM_CORES-1:0][RATIO_W-1:0] applied;
   logic [NUM_CORES-1:0]              capture;
   logic [NUM_CORES-1:0]              done_vec;

   core_div_regs #(
      .NUM_CORES (NUM_CORES),
      .RATIO_W   (RATIO_W),
      .ADDR_W    (ADDR_W),
      .DATA_W    (DATA_W)
   ) i_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_we    (bus_we),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .done_i    (done_vec),
      .div_field (div_field),
      .capture   (capture),
      .rst_req   (core_rst_req)
   );

   for (genvar n = 0; n < NUM_CORES; n++) begin : g_lane
      core_div_lane #(
         .RATIO_W   (RATIO_W),
         .MAX_RATIO (MAX_RATIO)
      ) i_lane (
         .clk       (clk),
         .rst_n     (rst_n),
         .capture   (capture[n]),
         .req_ratio (div_field[n]),
         .tick      (core_tick[n]),
         .ratio_o   (applied[n]),
         .done_o    (done_vec[n])
      );
   end

endmodule

module core_div_bank_chk #(
   parameter int NUM_CORES = 4,
   parameter int RATIO_W   = 6,
   parameter int MAX_RATIO = 3
) (
   input logic                              clk,
   input logic                              rst_n,
   input logic [NUM_CORES-1:0]              core_tick,
   input logic [NUM_CORES-1:0][RATIO_W-1:0] applied,
   input logic [NUM_CORES-1:0]              done_vec
);

   assert_reset_ticks_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (&core_tick));

   for (genvar n = 0; n < NUM_CORES; n++) begin : g_core
      assert_ratio_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
         (applied[n] >= RATIO_W'(1)) && (applied[n] <= RATIO_W'(MAX_RATIO)));

      assert_change_at_boundary_R5: assert property (@(posedge clk) disable iff (!rst_n)
         !$stable(applied[n]) |-> $past(core_tick[n]));

      assert_single_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
         (core_tick[n] && applied[n] != RATIO_W'(1))
         |=> (!core_tick[n] || applied[n] == RATIO_W'(1)));

      assert_done_on_apply_R11: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(done_vec[n]) |-> $past(core_tick[n]));
   end

endmodule

bind core_div_bank core_div_bank_chk #(
   .NUM_CORES (NUM_CORES),
   .RATIO_W   (RATIO_W),
   .MAX_RATIO (MAX_RATIO)
) i_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .core_tick (core_tick),
   .applied   (applied),
   .done_vec  (done_vec)
);

// File: tb/test_core_div_bank.sv
module test_core_div_bank;

   localparam int NC = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_we = 1'b0;
   logic [3:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [NC-1:0] core_tick;
   logic [NC-1:0] core_rst_req;

   int checks = 0;
   int errors = 0;
   bit cmp_on = 1'b0;

   // behavioural reference state
   int   m_ratio [NC];
   int   m_cnt   [NC];
   int   m_stage [NC];
   bit   m_pend  [NC];
   bit   m_done  [NC];
   int   m_div   [NC];
   bit   m_trig;
   bit [NC-1:0] m_reload;
   bit [7:0]    m_rstreq;
   int   m_fabric;

   always #10 clk = ~clk;

   core_div_bank i_core_div_bank (
      .clk          (clk),
      .rst_n        (rst_n),
      .bus_we       (bus_we),
      .bus_addr     (bus_addr),
      .bus_wdata    (bus_wdata),
      .bus_rdata    (bus_rdata),
      .core_tick    (core_tick),
      .core_rst_req (core_rst_req)
   );

   function automatic int clampv(int v);
      if (v == 0) return 1;
      if (v > 3)  return 3;
      return v;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int n = 0; n < NC; n++) begin
            m_ratio[n] = 1; m_cnt[n] = 0; m_stage[n] = 1;
            m_pend[n] = 0;  m_done[n] = 0; m_div[n] = 0;
         end
         m_trig = 0; m_reload = '0; m_rstreq = '0; m_fabric = 0;
      end else begin
         for (int n = 0; n < NC; n++) begin
            if (m_cnt[n] == m_ratio[n] - 1) begin
               if (m_pend[n]) begin
                  m_ratio[n] = m_stage[n];
                  m_done[n]  = 1;
                  m_pend[n]  = 0;
               end
               m_cnt[n] = 0;
            end else begin
               m_cnt[n]++;
            end
         end
         if (bus_we) begin
            case (bus_addr)
               4'h0: begin
                  if (bus_wdata[24] && !m_trig) begin
                     for (int n = 0; n < NC; n++) begin
                        if (bus_wdata[20+n]) begin
                           m_stage[n] = clampv(m_div[n]);
                           m_pend[n]  = 1;
                           m_done[n]  = 0;
                        end
                     end
                  end
                  m_trig   = bus_wdata[24];
                  m_reload = bus_wdata[23:20];
                  m_rstreq = bus_wdata[15:8];
               end
               4'h8: m_fabric = int'(bus_wdata[21:16]);
               4'hC: for (int n = 0; n < NC; n++) m_div[n] = int'(bus_wdata[n*8 +: 6]);
               default: ;
            endcase
         end
      end
   end

   function automatic logic [31:0] model_read(logic [3:0] a);
      logic [31:0] r = '0;
      case (a)
         4'h0: begin
            r[24] = m_trig; r[23:20] = m_reload; r[15:8] = m_rstreq;
            for (int n = 0; n < NC; n++) r[n] = m_done[n];
         end
         4'h8: r[21:16] = m_fabric[5:0];
         4'hC: for (int n = 0; n < NC; n++) r[n*8 +: 6] = m_div[n][5:0];
         default: ;
      endcase
      return r;
   endfunction

   task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
      end
   endtask

   // strobes and reset requests against the model on every cycle
   always @(negedge clk) begin
      if (rst_n && cmp_on) begin
         logic [NC-1:0] et;
         logic [NC-1:0] er;
         for (int n = 0; n < NC; n++) begin
            et[n] = (m_cnt[n] == m_ratio[n] - 1);
            er[n] = m_rstreq[n];
         end
         chk(core_tick == et, "R3 R5 R6 R7 R8 strobe", 32'(core_tick), 32'(et));
         chk(core_rst_req == er, "R10 reset request", 32'(core_rst_req), 32'(er));
      end
   end

   task automatic wr(logic [3:0] a, logic [31:0] d);
      @(negedge clk);
      bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_we = 1'b0; bus_wdata = '0;
   endtask

   task automatic rd_exp(logic [3:0] a, logic [31:0] exp, string tag);
      @(negedge clk);
      bus_addr = a;
      #1;
      chk(bus_rdata === exp, tag, bus_rdata, exp);
   endtask

   task automatic rd_model(logic [3:0] a, string tag);
      @(negedge clk);
      bus_addr = a;
      #1;
      chk(bus_rdata === model_read(a), tag, bus_rdata, model_read(a));
   endtask

   task automatic idle(int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      cmp_on = 1'b1;
      // R1: reset state
      rd_exp(4'h0, 32'h0, "R1 control after reset");
      rd_exp(4'h8, 32'h0, "R1 second control after reset");
      rd_exp(4'hC, 32'h0, "R1 divider after reset");
      chk(core_tick == 4'hF, "R1 strobes high", 32'(core_tick), 32'hF);
      chk(core_rst_req == 4'h0, "R1 no reset request", 32'(core_rst_req), 32'h0);

      // R2 R3: field storage and staging only
      wr(4'hC, 32'hC5C2C2C3);
      rd_exp(4'hC, 32'h05020203, "R2 divider readback");
      idle(8);
      chk(core_tick == 4'hF, "R3 no change before trigger", 32'(core_tick), 32'hF);

      // R4 R7: reload cores 0,1,3 only
      wr(4'h0, 32'h00B00000);
      wr(4'h0, 32'h01B00000);
      idle(20);
      rd_exp(4'h0, 32'h01B0000B, "R4 R11 control after trigger");

      // R8 R11: clear leaves ratios and done flags
      wr(4'h0, 32'h0000000F);
      rd_exp(4'h0, 32'h0000000B, "R8 R11 control after clear");
      idle(12);

      // R8: level on an already-set trigger must not stage
      wr(4'h0, 32'h01000000);
      wr(4'hC, 32'h01010101);
      wr(4'h0, 32'h01F00000);
      idle(12);
      rd_model(4'h0, "R8 control no restage");
      wr(4'h0, 32'h0);

      // R7: zero request becomes 1
      wr(4'hC, 32'h00000000);
      wr(4'h0, 32'h01100000);
      idle(10);
      wr(4'h0, 32'h0);
      rd_model(4'h0, "R7 R11 control after zero request");

      // R5: triggers at every phase of a running period
      for (int off = 0; off < 6; off++) begin
         wr(4'hC, (off % 2 == 0) ? 32'h00000300 : 32'h00000200);
         idle(off);
         wr(4'h0, 32'h00200000);
         wr(4'h0, 32'h01200000);
         idle(7);
         wr(4'h0, 32'h0);
         rd_model(4'h0, "R5 control after phased trigger");
      end

      // R9: fabric ratio
      wr(4'h8, 32'hFFFFFFFF);
      rd_exp(4'h8, 32'h003F0000, "R9 fabric readback");

      // R10: reset requests
      wr(4'h0, 32'h0000FF00);
      rd_model(4'h0, "R10 control with reset requests");
      chk(core_rst_req == 4'hF, "R10 reset request out", 32'(core_rst_req), 32'hF);

      // R12: unmapped offsets
      wr(4'h4, 32'hFFFFFFFF);
      rd_exp(4'h4, 32'h0, "R12 unmapped read");
      rd_model(4'h0, "R12 control untouched");
      rd_model(4'h8, "R12 second control untouched");
      rd_model(4'hC, "R12 divider untouched");
      idle(10);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule